// File: doc/BRIEF.md
# DSP Data Address Generator

This block forms the data-memory address for each operand access of a signal-processing datapath. A request arrives with a mode code, a pointer-register select, a 16-bit instruction address field and a 16-bit signed displacement. The block returns a registered 24-bit effective address and a valid flag one clock later. It holds eight 24-bit pointer registers, two step registers, two circular-buffer descriptors (a start and a span each), a page register and a window-width register for bit-reversed stepping. Software loads all of these through a single write port.

The modes are: page-based direct addressing, pointer plus displacement, pointer plus step register, post-increment, post-decrement, circular increment, circular decrement, and bit-reversed stepping. In every post-modify mode the address issued is the pointer value from before the update. The updated pointer is used from the next cycle onward. The two circular descriptors are independent, so a multiply-accumulate loop can walk a coefficient ring and a sample ring in alternate cycles. The bit-reversed mode propagates the carry from the high end of a programmable window toward bit 0. A linear FFT output count then comes out in natural order with no extra cycles.

Top module: `dsp_addr_gen`

## Requirements
- R1: After reset, `ea` is 0, `ea_valid` is 0, and every pointer, step, descriptor, page and window register holds 0.
- R2: With `req` high and mode code 1 (direct), in the next cycle `ea_valid` is 1 and `ea` is {page register[7:0], `instr`[15:0]}.
- R3: Mode code 2 gives `ea` = pointer[`ar_sel`] + `disp` sign-extended to 24 bits, modulo 2^24. The pointer is unchanged.
- R4: Mode code 3 gives `ea` = pointer[`ar_sel`] + step[`xsel`], modulo 2^24. The pointer is unchanged.
- R5: Mode code 4 (post-increment) and mode code 5 (post-decrement) issue the current pointer value as `ea`. The pointer then steps by +1 or -1 modulo 2^24, and the new value is used by the next access, including an access in the very next cycle.
- R6: Mode code 6 (circular increment) issues the pointer. It then moves it to pointer+1, except that a pointer equal to start+span-1 of descriptor `xsel` returns to start.
- R7: Mode code 7 (circular decrement) issues the pointer. It then moves it to pointer-1, except that a pointer equal to start of descriptor `xsel` goes to start+span-1.
- R8: The two circular descriptors act independently. Accesses that alternate between them keep separate ring positions.
- R9: Mode code 8 (bit-reversed) issues the pointer. It then adds step[`xsel`] to the low N bits of the pointer, with the carry running from bit N-1 toward bit 0 and dropped past bit 0. N is the window register, and the bits above the window are kept.
- R10: With `req` low, or with mode code 0 or any code from 9 to 15, `ea_valid` is 0 in the next cycle and no pointer changes.
- R11: When a software write and a post-modify hit the same pointer in one cycle, the written value is kept. A write to a different pointer in that cycle leaves the post-modify intact.
- R12: The write port decodes `wr_addr` as follows: 0-7 pointers, 8-9 step registers, 10-11 descriptor starts, 12-13 descriptor spans, 14 page (low 8 bits of `wr_data`), 15 window width (low 5 bits).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request strobe |
| mode | input | 4 | Addressing mode code |
| ar_sel | input | 3 | Pointer register select |
| xsel | input | 1 | Step register and circular descriptor select |
| instr | input | 16 | Instruction address field for direct mode |
| disp | input | 16 | Signed displacement |
| wr_en | input | 1 | Software register write enable |
| wr_addr | input | 4 | Software register write target |
| wr_data | input | 24 | Software register write data |
| ea | output | 24 | Registered effective address |
| ea_valid | output | 1 | Effective address valid |

## Verification
Two functions can act in the same cycle: a post-modify step of a pointer and a software load of that pointer. The bench drives a post-increment request and a write to the same pointer on one clock edge. It then requires the pre-update address on `ea` and the written value in the pointer when it is read back through a displacement-zero access. A second run pairs the post-increment with a write to a different pointer, and both updates must be visible afterwards.

// File: rtl/dag_pkg.sv
package dag_pkg;
    typedef enum logic [3:0] {
        M_NONE    = 4'd0,
        M_DIRECT  = 4'd1,
        M_DISP    = 4'd2,
        M_INDEX   = 4'd3,
        M_POSTINC = 4'd4,
        M_POSTDEC = 4'd5,
        M_CIRCINC = 4'd6,
        M_CIRCDEC = 4'd7,
        M_BITREV  = 4'd8
    } mode_e;
endpackage

// File: rtl/dag_circ_step.sv
module dag_circ_step #(
    parameter int AW = 24
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] start,
    input  logic [AW-1:0] span,
    input  logic          down,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] last;

    always_comb begin
        last = start + span - AW'(1);
        if (down) nxt = (cur == start) ? last : cur - AW'(1);
        else      nxt = (cur == last) ? start : cur + AW'(1);
    end
endmodule

// File: rtl/dag_bitrev_add.sv
module dag_bitrev_add #(
    parameter int AW = 24,
    parameter int BW = 5
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic [BW-1:0] nbits,
    output logic [AW-1:0] s
);
    logic c;

    always_comb begin
        c = 1'b0;
        s = a;
        for (int i = AW - 1; i >= 0; i--) begin
            if (i < int'(nbits)) begin
                s[i] = a[i] ^ b[i] ^ c;
                c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
            end
        end
    end
endmodule

// File: rtl/dsp_addr_gen.sv
module dsp_addr_gen
    import dag_pkg::*;
#(
    parameter int AW   = 24,
    parameter int NAR  = 8,
    parameter int DPW  = 8,
    parameter int FW   = 16,
    parameter int NBUF = 2,
    parameter int ARSW = $clog2(NAR),
    parameter int XW   = (NBUF > 1) ? $clog2(NBUF) : 1,
    parameter int WAW  = $clog2(NAR + 3 * NBUF + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [3:0]      mode,
    input  logic [ARSW-1:0] ar_sel,
    input  logic [XW-1:0]   xsel,
    input  logic [FW-1:0]   instr,
    input  logic [FW-1:0]   disp,
    input  logic            wr_en,
    input  logic [WAW-1:0]  wr_addr,
    input  logic [AW-1:0]   wr_data,
    output logic [AW-1:0]   ea,
    output logic            ea_valid
);
    localparam int BW     = $clog2(AW + 1);
    localparam int A_IDX  = NAR;
    localparam int A_BASE = NAR + NBUF;
    localparam int A_LEN  = NAR + 2 * NBUF;
    localparam int A_DP   = NAR + 3 * NBUF;
    localparam int A_BRN  = A_DP + 1;

    logic [NAR-1:0][AW-1:0]  ar_q;
    logic [NBUF-1:0][AW-1:0] idx_q, base_q, len_q;
    logic [DPW-1:0]          dp_q;
    logic [BW-1:0]           brn_q;

    mode_e         m;
    logic [AW-1:0] cur, step, circ_nxt, brev_nxt;
    logic [AW-1:0] ea_n, ar_n;
    logic          hit, upd;

    assign m    = mode_e'(mode);
    assign cur  = ar_q[ar_sel];
    assign step = idx_q[xsel];

    dag_circ_step #(.AW(AW)) i_circ (
        .cur   (cur),
        .start (base_q[xsel]),
        .span  (len_q[xsel]),
        .down  (m == M_CIRCDEC),
        .nxt   (circ_nxt)
    );

    dag_bitrev_add #(.AW(AW), .BW(BW)) i_brev (
        .a     (cur),
        .b     (step),
        .nbits (brn_q),
        .s     (brev_nxt)
    );

    // Next-value selection per mode
    always_comb begin
        hit  = 1'b1;
        upd  = 1'b0;
        ea_n = cur;
        ar_n = cur;
        unique case (m)
            M_DIRECT:  ea_n = {dp_q, instr};
            M_DISP:    ea_n = cur + {{(AW-FW){disp[FW-1]}}, disp};
            M_INDEX:   ea_n = cur + step;
            M_POSTINC: begin upd = 1'b1; ar_n = cur + AW'(1); end
            M_POSTDEC: begin upd = 1'b1; ar_n = cur - AW'(1); end
            M_CIRCINC,
            M_CIRCDEC: begin upd = 1'b1; ar_n = circ_nxt; end
            M_BITREV:  begin upd = 1'b1; ar_n = brev_nxt; end
            default:   hit = 1'b0;
        endcase
    end

    // Register state; a software write overrides a same-cycle post-modify
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea       <= '0;
            ea_valid <= 1'b0;
            ar_q     <= '0;
            idx_q    <= '0;
            base_q   <= '0;
            len_q    <= '0;
            dp_q     <= '0;
            brn_q    <= '0;
        end else begin
            ea_valid <= req && hit;
            if (req && hit) ea <= ea_n;
            if (req && hit && upd) ar_q[ar_sel] <= ar_n;
            if (wr_en && wr_addr < WAW'(NAR)) ar_q[wr_addr[ARSW-1:0]] <= wr_data;
            for (int i = 0; i < NBUF; i++) begin
                if (wr_en && wr_addr == WAW'(A_IDX + i))  idx_q[i]  <= wr_data;
                if (wr_en && wr_addr == WAW'(A_BASE + i)) base_q[i] <= wr_data;
                if (wr_en && wr_addr == WAW'(A_LEN + i))  len_q[i]  <= wr_data;
            end
            if (wr_en && wr_addr == WAW'(A_DP))  dp_q  <= wr_data[DPW-1:0];
            if (wr_en && wr_addr == WAW'(A_BRN)) brn_q <= wr_data[BW-1:0];
        end
    end
endmodule

// File: rtl/dag_chk.sv
module dag_chk
    import dag_pkg::*;
#(
    parameter int AW   = 24,
    parameter int NAR  = 8,
    parameter int FW   = 16,
    parameter int NBUF = 2,
    parameter int ARSW = 3,
    parameter int XW   = 1,
    parameter int WAW  = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req,
    input logic [3:0]            mode,
    input logic [ARSW-1:0]       ar_sel,
    input logic [XW-1:0]         xsel,
    input logic [FW-1:0]         instr,
    input logic                  wr_en,
    input logic [WAW-1:0]        wr_addr,
    input logic [AW-1:0]         wr_data,
    input logic [AW-1:0]         ea,
    input logic                  ea_valid,
    input logic [NAR-1:0][AW-1:0]  ar_q,
    input logic [NBUF-1:0][AW-1:0] base_q,
    input logic [NBUF-1:0][AW-1:0] len_q
);
    logic same_wr, circ_mode, in_ring;
    logic [AW-1:0] last;

    assign same_wr   = wr_en && (wr_addr == WAW'(ar_sel));
    assign circ_mode = (mode == M_CIRCINC) || (mode == M_CIRCDEC);
    assign last      = base_q[xsel] + len_q[xsel] - AW'(1);
    assign in_ring   = (len_q[xsel] != '0) && (last >= base_q[xsel]) &&
                       (ar_q[ar_sel] >= base_q[xsel]) && (ar_q[ar_sel] <= last);

    a_r10_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !ea_valid);

    a_r2_direct_field: assert property (@(posedge clk) disable iff (!rst_n)
        req && mode == M_DIRECT |=> ea_valid && ea[FW-1:0] == $past(instr));

    a_r5_postinc_step: assert property (@(posedge clk) disable iff (!rst_n)
        req && mode == M_POSTINC && !same_wr |=>
        ar_q[$past(ar_sel)] == $past(ar_q[ar_sel]) + AW'(1));

    a_r5_issue_old_value: assert property (@(posedge clk) disable iff (!rst_n)
        req && mode == M_POSTDEC |=> ea == $past(ar_q[ar_sel]));

    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr < WAW'(NAR) |=>
        ar_q[$past(wr_addr[ARSW-1:0])] == $past(wr_data));

    a_r6_ring_stays_inside: assert property (@(posedge clk) disable iff (!rst_n)
        req && circ_mode && in_ring && !wr_en |=>
        ar_q[$past(ar_sel)] >= $past(base_q[xsel]) && ar_q[$past(ar_sel)] <= $past(last));
endmodule

bind dsp_addr_gen dag_chk #(
    .AW(AW), .NAR(NAR), .FW(FW), .NBUF(NBUF), .ARSW(ARSW), .XW(XW), .WAW(WAW)
) i_dag_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .ar_sel(ar_sel), .xsel(xsel),
    .instr(instr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ea(ea), .ea_valid(ea_valid), .ar_q(ar_q), .base_q(base_q), .len_q(len_q)
);

// File: tb/test_dsp_addr_gen.sv
module test_dsp_addr_gen;
    import dag_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [3:0]  mode = '0;
    logic [2:0]  ar_sel = '0;
    logic        xsel = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] disp = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic [23:0] ea;
    logic        ea_valid;

    int checks = 0;
    int errs = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dsp_addr_gen i_dsp_addr_gen (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .ar_sel(ar_sel),
        .xsel(xsel), .instr(instr), .disp(disp), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ea(ea), .ea_valid(ea_valid)
    );

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic [3:0] m, input logic [2:0] s, input logic x,
                       input logic [15:0] f, input logic [15:0] d);
        req = 1'b1; mode = m; ar_sel = s; xsel = x; instr = f; disp = d;
        @(negedge clk);
        req = 1'b0; wr_en = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [23:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] s, output logic [23:0] v);
        acc(M_DISP, s, 1'b0, 16'h0, 16'h0);
        v = ea;
    endtask

    function automatic logic [23:0] rev(input int k, input int n);
        logic [23:0] r = '0;
        for (int i = 0; i < n; i++) r[n-1-i] = k[i];
        return r;
    endfunction

    task automatic t_reset();
        logic [23:0] v;
        chk("R1 ea", ea, 24'h0);
        chk("R1 valid", {23'h0, ea_valid}, 24'h0);
        peek(3'd3, v);
        chk("R1 pointer", v, 24'h0);
    endtask

    task automatic t_direct();
        wr(4'd14, 24'h00005A);
        acc(M_DIRECT, 3'd0, 1'b0, 16'hBEEF, 16'h0);
        chk("R2 valid", {23'h0, ea_valid}, 24'h1);
        chk("R2 ea", ea, 24'h5ABEEF);
        wr(4'd14, 24'h0003C7);
        acc(M_DIRECT, 3'd0, 1'b0, 16'h0001, 16'h0);
        chk("R12 page low bits", ea, 24'hC70001);
    endtask

    task automatic t_indirect();
        logic [23:0] v;
        wr(4'd1, 24'h001000);
        acc(M_DISP, 3'd1, 1'b0, 16'h0, 16'h0010);
        chk("R3 plus", ea, 24'h001010);
        acc(M_DISP, 3'd1, 1'b0, 16'h0, 16'hFFF0);
        chk("R3 minus", ea, 24'h000FF0);
        peek(3'd1, v);
        chk("R3 unchanged", v, 24'h001000);
        wr(4'd9, 24'h000200);
        acc(M_INDEX, 3'd1, 1'b1, 16'h0, 16'h0);
        chk("R4 indexed", ea, 24'h001200);
        peek(3'd1, v);
        chk("R4 unchanged", v, 24'h001000);
    endtask

    task automatic t_post();
        logic [23:0] v;
        wr(4'd4, 24'h000010);
        acc(M_POSTINC, 3'd4, 1'b0, 16'h0, 16'h0);
        chk("R5 inc issue", ea, 24'h000010);
        peek(3'd4, v);
        chk("R5 inc result", v, 24'h000011);
        acc(M_POSTDEC, 3'd4, 1'b0, 16'h0, 16'h0);
        chk("R5 dec issue", ea, 24'h000011);
        peek(3'd4, v);
        chk("R5 dec result", v, 24'h000010);
        wr(4'd4, 24'h000000);
        acc(M_POSTDEC, 3'd4, 1'b0, 16'h0, 16'h0);
        chk("R5 dec at zero", ea, 24'h000000);
        acc(M_POSTINC, 3'd4, 1'b0, 16'h0, 16'h0);
        chk("R5 back to back", ea, 24'hFFFFFF);
        acc(M_POSTINC, 3'd4, 1'b0, 16'h0, 16'h0);
        chk("R5 wrap up", ea, 24'h000000);
    endtask

    task automatic t_circ();
        logic [23:0] e0 [4] = '{24'h43, 24'h44, 24'h40, 24'h41};
        logic [23:0] e1 [4] = '{24'h42, 24'h41, 24'h40, 24'h44};
        logic [23:0] ea_ring [3] = '{24'h43, 24'h44, 24'h40};
        logic [23:0] eb_ring [3] = '{24'h201, 24'h202, 24'h200};
        wr(4'd10, 24'h40); wr(4'd12, 24'd5); wr(4'd2, 24'h43);
        for (int k = 0; k < 4; k++) begin
            acc(M_CIRCINC, 3'd2, 1'b0, 16'h0, 16'h0);
            chk("R6 ring up", ea, e0[k]);
        end
        for (int k = 0; k < 4; k++) begin
            acc(M_CIRCDEC, 3'd2, 1'b0, 16'h0, 16'h0);
            chk("R7 ring down", ea, e1[k]);
        end
        wr(4'd11, 24'h200); wr(4'd13, 24'd3); wr(4'd3, 24'h201);
        for (int k = 0; k < 3; k++) begin
            acc(M_CIRCINC, 3'd2, 1'b0, 16'h0, 16'h0);
            chk("R8 ring zero", ea, ea_ring[k]);
            acc(M_CIRCINC, 3'd3, 1'b1, 16'h0, 16'h0);
            chk("R8 ring one", ea, eb_ring[k]);
        end
    endtask

    task automatic t_bitrev();
        wr(4'd15, 24'd3); wr(4'd8, 24'd4); wr(4'd6, 24'h100);
        for (int k = 0; k < 9; k++) begin
            acc(M_BITREV, 3'd6, 1'b0, 16'h0, 16'h0);
            chk("R9 eight point", ea, 24'h100 | rev(k % 8, 3));
        end
        wr(4'd15, 24'd4); wr(4'd8, 24'd8); wr(4'd6, 24'h230);
        for (int k = 0; k < 4; k++) begin
            acc(M_BITREV, 3'd6, 1'b0, 16'h0, 16'h0);
            chk("R9 sixteen point", ea, 24'h230 | rev(k, 4));
        end
    endtask

    task automatic t_idle();
        logic [23:0] v;
        wr(4'd7, 24'h55);
        mode = M_POSTINC; ar_sel = 3'd7; req = 1'b0;
        @(negedge clk);
        chk("R10 no req", {23'h0, ea_valid}, 24'h0);
        acc(M_NONE, 3'd7, 1'b0, 16'h0, 16'h0);
        chk("R10 mode none", {23'h0, ea_valid}, 24'h0);
        acc(4'hC, 3'd7, 1'b0, 16'h0, 16'h0);
        chk("R10 unused code", {23'h0, ea_valid}, 24'h0);
        peek(3'd7, v);
        chk("R10 pointer kept", v, 24'h55);
    endtask

    task automatic t_collide();
        logic [23:0] v;
        wr(4'd5, 24'h10);
        wr_en = 1'b1; wr_addr = 4'd5; wr_data = 24'h777;
        acc(M_POSTINC, 3'd5, 1'b0, 16'h0, 16'h0);
        chk("R11 issue old", ea, 24'h10);
        peek(3'd5, v);
        chk("R11 write wins", v, 24'h777);
        wr_en = 1'b1; wr_addr = 4'd0; wr_data = 24'h99;
        acc(M_POSTINC, 3'd5, 1'b0, 16'h0, 16'h0);
        peek(3'd5, v);
        chk("R11 other step kept", v, 24'h778);
        peek(3'd0, v);
        chk("R11 other write", v, 24'h99);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_indirect();
        t_post();
        t_circ();
        t_bitrev();
        t_idle();
        t_collide();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errs++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule